// File: doc/BRIEF.md
# Packet Number Completion Queues

This block keeps two short first-in-first-out queues of packet numbers for the buffer manager of a network controller. The receive engine appends the number of each packet it has stored. Software removes that number through a buffer-manager command once the packet is handled. The transmit engine appends the number of each packet it has finished sending. Software removes that number by acknowledging the transmit interrupt.

Both queue heads are presented side by side in one read-only status word, and each head has its own empty flag. Software copies a head field unchanged into its active packet number register. A head value only means something while its empty flag is clear, and an empty queue shows a zero head. The not-empty state of each queue drives a separate interrupt status output. A push that finds its queue full is lost and raises a sticky overflow flag for that queue.

Top module: `pnq_top`

## Requirements
- R1: The status word has the transmit head in bits 5:0, the transmit empty flag in bit 7, the receive head in bits 13:8 and the receive empty flag in bit 15. Bits 6 and 14 are always 0.
- R2: An empty flag is 1 exactly when its queue holds no entries. While the flag is 1, the matching head field reads 0.
- R3: Each queue holds up to 4 entries in first-in-first-out order. Its head field shows the oldest entry.
- R4: The receive head is removed only in a cycle with cmd_valid_i high and cmd_code_i equal to 3 or 4. Any other code, or cmd_valid_i low, leaves the receive queue unchanged. A removal request on an empty queue is ignored.
- R5: The transmit head is removed in a cycle with tx_ack_i high. An acknowledge on an empty transmit queue is ignored.
- R6: A push and a removal on the same queue in one cycle leave its entry count unchanged. The head advances to the next entry and the new number is appended at the tail. This also holds when the queue is full.
- R7: A push to a full queue with no removal in the same cycle is dropped. It sets that queue's overflow output, which stays 1 until reset.
- R8: rx_int_o is the inverse of the receive empty flag, and tx_int_o is the inverse of the transmit empty flag.
- R9: Asynchronous reset empties both queues and clears both overflow flags. After reset the status word reads 0x8080.
- R10: A push or a removal becomes visible in the status word after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_push_i | input | 1 | Receive engine appends rx_pkt_i |
| rx_pkt_i | input | 6 | Packet number from the receive engine |
| tx_push_i | input | 1 | Transmit engine appends tx_pkt_i |
| tx_pkt_i | input | 6 | Packet number from the transmit engine |
| cmd_valid_i | input | 1 | Buffer-manager command strobe |
| cmd_code_i | input | 4 | Buffer-manager command code |
| tx_ack_i | input | 1 | Transmit interrupt acknowledge |
| status_o | output | 16 | Read-only status word with both heads and empty flags |
| rx_int_o | output | 1 | Receive queue not empty |
| tx_int_o | output | 1 | Transmit queue not empty |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| tx_ovf_o | output | 1 | Sticky transmit overflow |

## Verification
Some properties are checked on every cycle. The reserved status bits stay zero, and an empty flag always forces a zero head. Each interrupt output tracks its empty flag, and an overflow flag never clears without reset. A push always leaves its queue non-empty. An ignored removal keeps a queue empty, and an idle cycle leaves its half of the status word unchanged. The bench scenarios are needed for the rest: the first-in-first-out order of values, decoding of the two removal codes against the other codes, the point at which the fourth entry fills a queue, and a push and a removal together on a full queue.

// File: rtl/pnq_pkg.sv
package pnq_pkg;
  localparam int unsigned PKT_W  = 6;
  localparam int unsigned DEPTH  = 4;
  localparam int unsigned STAT_W = 16;
  localparam int unsigned NQ     = 2;
  localparam int unsigned Q_RX   = 0;
  localparam int unsigned Q_TX   = 1;
  localparam int unsigned CMD_W  = 4;
  // status word field positions (decoded by software)
  localparam int unsigned TX_HEAD_LSB = 0;
  localparam int unsigned TX_EMPTY    = 7;
  localparam int unsigned RX_HEAD_LSB = 8;
  localparam int unsigned RX_EMPTY    = 15;
  // command codes that remove the receive head
  localparam logic [CMD_W-1:0] CMD_RX_POP_A = 4'd3;
  localparam logic [CMD_W-1:0] CMD_RX_POP_B = 4'd4;
endpackage

// File: rtl/pnq_fifo.sv
module pnq_fifo #(
  parameter int unsigned W = 6,
  parameter int unsigned D = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         ovf_o
);
  localparam int unsigned PTR_W = (D > 1) ? $clog2(D) : 1;
  localparam int unsigned CNT_W = $clog2(D + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(D - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(D);

  logic [W-1:0]     mem_q [D];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             do_pop, do_push;

  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && ((cnt_q != FULL) || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(D); i++) mem_q[i] <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      end
      if (do_pop) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      if (push_i && !do_push) ovf_q <= 1'b1;
    end
  end

  assign empty_o = (cnt_q == '0);
  assign head_o  = empty_o ? '0 : mem_q[rd_q];
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/pnq_status.sv
module pnq_status
  import pnq_pkg::*;
(
  input  logic [PKT_W-1:0]  rx_head_i,
  input  logic              rx_empty_i,
  input  logic [PKT_W-1:0]  tx_head_i,
  input  logic              tx_empty_i,
  output logic [STAT_W-1:0] status_o
);
  always_comb begin
    status_o = '0;
    status_o[TX_HEAD_LSB +: PKT_W] = tx_head_i;
    status_o[TX_EMPTY]             = tx_empty_i;
    status_o[RX_HEAD_LSB +: PKT_W] = rx_head_i;
    status_o[RX_EMPTY]             = rx_empty_i;
  end
endmodule

// File: rtl/pnq_top.sv
module pnq_top
  import pnq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_push_i,
  input  logic [PKT_W-1:0]  rx_pkt_i,
  input  logic              tx_push_i,
  input  logic [PKT_W-1:0]  tx_pkt_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_code_i,
  input  logic              tx_ack_i,
  output logic [STAT_W-1:0] status_o,
  output logic              rx_int_o,
  output logic              tx_int_o,
  output logic              rx_ovf_o,
  output logic              tx_ovf_o
);
  logic             push [NQ];
  logic             pop  [NQ];
  logic [PKT_W-1:0] din  [NQ];
  logic [PKT_W-1:0] head [NQ];
  logic             empty[NQ];
  logic             ovf  [NQ];

  assign push[Q_RX] = rx_push_i;
  assign din[Q_RX]  = rx_pkt_i;
  assign pop[Q_RX]  = cmd_valid_i &&
                      ((cmd_code_i == CMD_RX_POP_A) || (cmd_code_i == CMD_RX_POP_B));
  assign push[Q_TX] = tx_push_i;
  assign din[Q_TX]  = tx_pkt_i;
  assign pop[Q_TX]  = tx_ack_i;

  for (genvar q = 0; q < int'(NQ); q++) begin : g_q
    pnq_fifo #(.W(PKT_W), .D(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[q]),
      .data_i  (din[q]),
      .pop_i   (pop[q]),
      .head_o  (head[q]),
      .empty_o (empty[q]),
      .ovf_o   (ovf[q])
    );
  end

  pnq_status u_status (
    .rx_head_i  (head[Q_RX]),
    .rx_empty_i (empty[Q_RX]),
    .tx_head_i  (head[Q_TX]),
    .tx_empty_i (empty[Q_TX]),
    .status_o   (status_o)
  );

  assign rx_int_o = !empty[Q_RX];
  assign tx_int_o = !empty[Q_TX];
  assign rx_ovf_o = ovf[Q_RX];
  assign tx_ovf_o = ovf[Q_TX];
endmodule

// File: rtl/pnq_checker.sv
module pnq_checker
  import pnq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_push_i,
  input logic              tx_push_i,
  input logic              cmd_valid_i,
  input logic [CMD_W-1:0]  cmd_code_i,
  input logic              tx_ack_i,
  input logic [STAT_W-1:0] status_o,
  input logic              rx_int_o,
  input logic              tx_int_o,
  input logic              rx_ovf_o,
  input logic              tx_ovf_o
);
  logic rx_pop_req;
  assign rx_pop_req = cmd_valid_i &&
                      ((cmd_code_i == CMD_RX_POP_A) || (cmd_code_i == CMD_RX_POP_B));

  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[6] == 1'b0) && (status_o[14] == 1'b0));

  a_r2_rx_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[RX_EMPTY] |-> (status_o[RX_HEAD_LSB +: PKT_W] == '0));

  a_r2_tx_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[TX_EMPTY] |-> (status_o[TX_HEAD_LSB +: PKT_W] == '0));

  a_r8_int_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_int_o == !status_o[RX_EMPTY]) && (tx_int_o == !status_o[TX_EMPTY]));

  a_r7_rx_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovf_o |=> rx_ovf_o);

  a_r7_tx_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovf_o |=> tx_ovf_o);

  a_r10_rx_push_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i |=> !status_o[RX_EMPTY]);

  a_r10_tx_push_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_i |=> !status_o[TX_EMPTY]);

  a_r4_rx_empty_pop_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[RX_EMPTY] && !rx_push_i) |=> status_o[RX_EMPTY]);

  a_r5_tx_empty_ack_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[TX_EMPTY] && !tx_push_i) |=> status_o[TX_EMPTY]);

  a_r4_rx_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_push_i && !rx_pop_req) |=> $stable(status_o[15:8]));

  a_r5_tx_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_push_i && !tx_ack_i) |=> $stable(status_o[7:0]));
endmodule

bind pnq_top pnq_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_push_i   (rx_push_i),
  .tx_push_i   (tx_push_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_code_i  (cmd_code_i),
  .tx_ack_i    (tx_ack_i),
  .status_o    (status_o),
  .rx_int_o    (rx_int_o),
  .tx_int_o    (tx_int_o),
  .rx_ovf_o    (rx_ovf_o),
  .tx_ovf_o    (tx_ovf_o)
);

// File: tb/pnq_top_tb.sv
`timescale 1ns/1ps
module pnq_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_push_i = 1'b0;
  logic [5:0]  rx_pkt_i = '0;
  logic        tx_push_i = 1'b0;
  logic [5:0]  tx_pkt_i = '0;
  logic        cmd_valid_i = 1'b0;
  logic [3:0]  cmd_code_i = '0;
  logic        tx_ack_i = 1'b0;
  logic [15:0] status_o;
  logic        rx_int_o, tx_int_o, rx_ovf_o, tx_ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pnq_top u_dut (.*);

  typedef struct packed {
    logic       rp; logic [5:0] rd;
    logic       tp; logic [5:0] td;
    logic       cv; logic [3:0] cc; logic ta;
    logic       ere; logic [5:0] erh;
    logic       ete; logic [5:0] eth;
    logic       ero; logic eto;
  } vec_t;

  localparam int NV = 19;
  // rp rd tp td cv cc ta | rx_empty rx_head tx_empty tx_head rx_ovf tx_ovf
  localparam vec_t VEC [NV] = '{
    '{1'b1,6'd5, 1'b0,6'd0, 1'b0,4'd0,1'b0, 1'b0,6'd5, 1'b1,6'd0, 1'b0,1'b0}, // R10 rx push
    '{1'b0,6'd0, 1'b1,6'd9, 1'b0,4'd0,1'b0, 1'b0,6'd5, 1'b0,6'd9, 1'b0,1'b0}, // R10 tx push
    '{1'b1,6'd7, 1'b0,6'd0, 1'b1,4'd3,1'b0, 1'b0,6'd7, 1'b0,6'd9, 1'b0,1'b0}, // R6 push+pop rx
    '{1'b0,6'd0, 1'b0,6'd0, 1'b1,4'd2,1'b0, 1'b0,6'd7, 1'b0,6'd9, 1'b0,1'b0}, // R4 other code
    '{1'b0,6'd0, 1'b1,6'd10,1'b0,4'd0,1'b1, 1'b0,6'd7, 1'b0,6'd10,1'b0,1'b0}, // R6 push+ack tx
    '{1'b0,6'd0, 1'b0,6'd0, 1'b0,4'd0,1'b1, 1'b0,6'd7, 1'b1,6'd0, 1'b0,1'b0}, // R5 ack
    '{1'b0,6'd0, 1'b0,6'd0, 1'b1,4'd4,1'b0, 1'b1,6'd0, 1'b1,6'd0, 1'b0,1'b0}, // R4 code 4
    '{1'b0,6'd0, 1'b0,6'd0, 1'b1,4'd3,1'b0, 1'b1,6'd0, 1'b1,6'd0, 1'b0,1'b0}, // R4 pop empty
    '{1'b0,6'd0, 1'b0,6'd0, 1'b0,4'd0,1'b1, 1'b1,6'd0, 1'b1,6'd0, 1'b0,1'b0}, // R5 ack empty
    '{1'b1,6'd63,1'b0,6'd0, 1'b0,4'd0,1'b0, 1'b0,6'd63,1'b1,6'd0, 1'b0,1'b0}, // R3 fill
    '{1'b1,6'd1, 1'b0,6'd0, 1'b0,4'd0,1'b0, 1'b0,6'd63,1'b1,6'd0, 1'b0,1'b0},
    '{1'b1,6'd2, 1'b0,6'd0, 1'b0,4'd0,1'b0, 1'b0,6'd63,1'b1,6'd0, 1'b0,1'b0},
    '{1'b1,6'd3, 1'b0,6'd0, 1'b0,4'd0,1'b0, 1'b0,6'd63,1'b1,6'd0, 1'b0,1'b0}, // R3 4th fits
    '{1'b1,6'd4, 1'b0,6'd0, 1'b0,4'd0,1'b0, 1'b0,6'd63,1'b1,6'd0, 1'b1,1'b0}, // R7 dropped
    '{1'b0,6'd0, 1'b0,6'd0, 1'b0,4'd3,1'b0, 1'b0,6'd63,1'b1,6'd0, 1'b1,1'b0}, // R4 no valid
    '{1'b0,6'd0, 1'b0,6'd0, 1'b1,4'd3,1'b0, 1'b0,6'd1, 1'b1,6'd0, 1'b1,1'b0}, // R3 order
    '{1'b0,6'd0, 1'b0,6'd0, 1'b1,4'd3,1'b0, 1'b0,6'd2, 1'b1,6'd0, 1'b1,1'b0},
    '{1'b0,6'd0, 1'b0,6'd0, 1'b1,4'd4,1'b0, 1'b0,6'd3, 1'b1,6'd0, 1'b1,1'b0},
    '{1'b0,6'd0, 1'b0,6'd0, 1'b1,4'd3,1'b0, 1'b1,6'd0, 1'b1,6'd0, 1'b1,1'b0}  // R2 empty again
  };

  function automatic logic [15:0] mk(logic re, logic [5:0] rh, logic te, logic [5:0] th);
    return {re, 1'b0, rh, te, 1'b0, th};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // status word (R1), interrupts (R8), overflow flags (R7)
  task automatic chk_all(string tag, logic re, logic [5:0] rh, logic te, logic [5:0] th,
                         logic ro, logic to);
    chk({"R1 status ", tag}, status_o, mk(re, rh, te, th));
    chk({"R8 ints ", tag}, {14'd0, rx_int_o, tx_int_o}, {14'd0, !re, !te});
    chk({"R7 ovf ", tag}, {14'd0, rx_ovf_o, tx_ovf_o}, {14'd0, ro, to});
  endtask

  task automatic step(logic rp, logic [5:0] rd, logic tp, logic [5:0] td,
                      logic cv, logic [3:0] cc, logic ta);
    rx_push_i = rp; rx_pkt_i = rd; tx_push_i = tp; tx_pkt_i = td;
    cmd_valid_i = cv; cmd_code_i = cc; tx_ack_i = ta;
    @(negedge clk_i);
    rx_push_i = 1'b0; tx_push_i = 1'b0; cmd_valid_i = 1'b0; tx_ack_i = 1'b0;
    cmd_code_i = '0;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk_all("R9 reset", 1'b1, 6'd0, 1'b1, 6'd0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_all("R9 idle", 1'b1, 6'd0, 1'b1, 6'd0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].rp, VEC[i].rd, VEC[i].tp, VEC[i].td, VEC[i].cv, VEC[i].cc, VEC[i].ta);
      chk_all($sformatf("vec %0d", i), VEC[i].ere, VEC[i].erh, VEC[i].ete, VEC[i].eth,
              VEC[i].ero, VEC[i].eto);
    end

    // R3 / R7 on the transmit queue
    step(1'b0, 6'd0, 1'b1, 6'd11, 1'b0, 4'd0, 1'b0);
    step(1'b0, 6'd0, 1'b1, 6'd12, 1'b0, 4'd0, 1'b0);
    step(1'b0, 6'd0, 1'b1, 6'd13, 1'b0, 4'd0, 1'b0);
    step(1'b0, 6'd0, 1'b1, 6'd14, 1'b0, 4'd0, 1'b0);
    chk_all("R3 tx full", 1'b1, 6'd0, 1'b0, 6'd11, 1'b1, 1'b0);
    step(1'b0, 6'd0, 1'b1, 6'd15, 1'b0, 4'd0, 1'b0);
    chk_all("R7 tx drop", 1'b1, 6'd0, 1'b0, 6'd11, 1'b1, 1'b1);
    step(1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 4'd0, 1'b1);
    chk_all("R3 tx 2nd", 1'b1, 6'd0, 1'b0, 6'd12, 1'b1, 1'b1);
    step(1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 4'd0, 1'b1);
    chk_all("R3 tx 3rd", 1'b1, 6'd0, 1'b0, 6'd13, 1'b1, 1'b1);
    step(1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 4'd0, 1'b1);
    chk_all("R3 tx 4th", 1'b1, 6'd0, 1'b0, 6'd14, 1'b1, 1'b1);
    step(1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 4'd0, 1'b1);
    chk_all("R2 tx empty", 1'b1, 6'd0, 1'b1, 6'd0, 1'b1, 1'b1);

    // R6 push and pop together on a full receive queue
    step(1'b1, 6'd20, 1'b0, 6'd0, 1'b0, 4'd0, 1'b0);
    step(1'b1, 6'd21, 1'b0, 6'd0, 1'b0, 4'd0, 1'b0);
    step(1'b1, 6'd22, 1'b0, 6'd0, 1'b0, 4'd0, 1'b0);
    step(1'b1, 6'd23, 1'b0, 6'd0, 1'b0, 4'd0, 1'b0);
    step(1'b1, 6'd24, 1'b0, 6'd0, 1'b1, 4'd3, 1'b0);
    chk_all("R6 full swap", 1'b0, 6'd21, 1'b1, 6'd0, 1'b1, 1'b1);
    step(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 4'd4, 1'b0);
    step(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 4'd3, 1'b0);
    chk_all("R6 order a", 1'b0, 6'd23, 1'b1, 6'd0, 1'b1, 1'b1);
    step(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 4'd3, 1'b0);
    chk_all("R6 tail", 1'b0, 6'd24, 1'b1, 6'd0, 1'b1, 1'b1);

    // R9 reset in mid-run
    step(1'b0, 6'd0, 1'b1, 6'd30, 1'b0, 4'd0, 1'b0);
    rst_ni = 1'b0;
    #1;
    chk_all("R9 mid reset", 1'b1, 6'd0, 1'b1, 6'd0, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_all("R9 after", 1'b1, 6'd0, 1'b1, 6'd0, 1'b0, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule